// File: doc/BRIEF.md
# Frequency Lock Detector with Hysteresis

This block decides whether a synthesized clock runs at its programmed frequency. Running in the reference clock domain, it adds up pre-synchronized samples of synthesized-clock edge counts over a fixed window of reference cycles. At the end of each window it compares the total with a programmed expected count.

Acquiring lock needs two windows in a row that fall inside a tight tolerance band. Once locked, the flag drops only after a window that falls outside a band about twice as wide. This spacing keeps the flag from chattering near the edge of the band. The lock flag also qualifies release of a power-on reset sequencer.

A read strobe captures the flag into a read register. If a read lands on the same edge as a lock change, it returns the value held before that change. An external-clock mode holds the flag cleared. Any change of the programmed count or of the mode restarts the measurement.

Top module: `freq_lock_detect`

## Requirements
- R1: `edge_inc` is summed over exactly `WIN_LEN` reference cycles. The sum is judged once, on the cycle after the window closes, and the next window starts on the following cycle with no gap.
- R2: A window counts as inside the acquire band when |total − expected| ≤ expected >> 7, which is about 0.78 percent.
- R3: Two consecutive windows inside the acquire band set `lock`. A window outside the acquire band while unlocked discards any partial qualification.
- R4: While `lock` is set, it stays set for every window with |total − expected| ≤ expected >> 6, which is about 1.56 percent. A window beyond that clears it.
- R5: `lol_pulse` is high for exactly one cycle, on the same cycle that a measured window clears `lock`, and at no other time.
- R6: A change of `exp_cnt` clears `lock` on the next edge without a `lol_pulse` and restarts the window from zero.
- R7: While `mode` is 2'b10 (external clock), `lock` and `rst_ok` stay low whatever is measured. Codes 2'b00 and 2'b01 are both PLL modes. Changing `mode` restarts the window.
- R8: On an edge where `rd_stb` is sampled high, `rd_lock` takes the value `lock` held before that edge, even if `lock` changes on the same edge. Otherwise `rd_lock` holds.
- R9: `rst_ok` is high only while `lock` is high.
- R10: Synchronous reset clears `lock`, `lol_pulse`, `rst_ok`, `rd_lock` and the window counters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| exp_cnt | input | CNT_W | Programmed expected edge count per window |
| mode | input | 2 | 00 PLL, 01 PLL 1:1, 10 external clock |
| rd_stb | input | 1 | Read strobe for the lock flag |
| edge_inc | input | INC_W | Synthesized edges seen this reference cycle (pre-synchronized) |
| lock | output | 1 | Lock flag |
| lol_pulse | output | 1 | One-cycle loss-of-lock pulse |
| rst_ok | output | 1 | Reset-release qualifier |
| rd_lock | output | 1 | Lock value captured by the last read |

## Verification
The bench builds the block with a 16-cycle window, 16-bit counts and 8-bit increments, and uses an expected count of 1600. At that count the acquire band is ±12 and the release band is ±25. Each band edge is then reachable in one window: totals of ±12 and ±13 probe the acquire limit, and ±25 and ±26 probe the release limit. The short window also keeps every window boundary cheap to line up, which matters for the coincident-read cases and for the restart after a count or mode change.

// File: rtl/fld_pkg.sv
package fld_pkg;

    typedef enum logic [1:0] {
        MODE_PLL      = 2'b00,
        MODE_PLL_1TO1 = 2'b01,
        MODE_EXT      = 2'b10,
        MODE_RSVD     = 2'b11
    } fld_mode_e;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'b00,
        ST_QUAL   = 2'b01,
        ST_LOCKED = 2'b10
    } fld_state_e;

    typedef struct packed {
        logic vld;
        logic acq_ok;
        logic rel_ok;
    } fld_verdict_t;

    // Tight band uses this right shift of the expected count; loose band one less.
    localparam int unsigned ACQ_SHIFT = 7;

    function automatic logic is_ext(input logic [1:0] m);
        return m == MODE_EXT;
    endfunction

endpackage

// File: rtl/fld_window.sv
module fld_window #(
    parameter int unsigned WIN_LEN = 256,
    parameter int unsigned INC_W   = 8,
    parameter int unsigned ACC_W   = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [INC_W-1:0] edge_inc,
    output logic             meas_vld,
    output logic [ACC_W-1:0] meas_cnt
);
    localparam int unsigned WIN_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam logic [WIN_W-1:0] LAST = WIN_W'(WIN_LEN - 1);
    localparam bit NEED_SAT =
        (longint'(WIN_LEN) * ((longint'(1) << INC_W) - 1)) >= (longint'(1) << ACC_W);

    logic [WIN_W-1:0] wcnt;
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] sum;

    generate
        if (NEED_SAT) begin : g_sat
            logic [ACC_W:0] wide;
            always_comb begin
                wide = {1'b0, acc} + (ACC_W+1)'(edge_inc);
                sum  = wide[ACC_W] ? {ACC_W{1'b1}} : wide[ACC_W-1:0];
            end
        end else begin : g_plain
            always_comb sum = acc + ACC_W'(edge_inc);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            wcnt     <= '0;
            acc      <= '0;
            meas_vld <= 1'b0;
            meas_cnt <= '0;
        end else begin
            meas_vld <= 1'b0;
            if (wcnt == LAST) begin
                meas_cnt <= sum;
                meas_vld <= 1'b1;
                acc      <= '0;
                wcnt     <= '0;
            end else begin
                acc  <= sum;
                wcnt <= wcnt + 1'b1;
            end
        end
    end

    generate
        if (WIN_LEN > 1) begin : g_chk
            // R1
            meas_gap_chk: assert property (@(posedge clk) disable iff (rst)
                meas_vld |=> !meas_vld);
        end
    endgenerate

endmodule

// File: rtl/fld_judge.sv
module fld_judge
    import fld_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned ACC_W = 17
) (
    input  logic             meas_vld,
    input  logic [ACC_W-1:0] meas_cnt,
    input  logic [CNT_W-1:0] exp_cnt,
    output fld_verdict_t     verdict
);
    localparam int unsigned REL_SHIFT = ACQ_SHIFT - 1;

    logic [ACC_W-1:0] exp_ext;
    logic [ACC_W-1:0] err;
    logic [ACC_W-1:0] acq_tol;
    logic [ACC_W-1:0] rel_tol;

    always_comb begin
        exp_ext = ACC_W'(exp_cnt);
        err     = (meas_cnt >= exp_ext) ? (meas_cnt - exp_ext) : (exp_ext - meas_cnt);
        acq_tol = exp_ext >> ACQ_SHIFT;
        rel_tol = exp_ext >> REL_SHIFT;
        verdict.vld    = meas_vld;
        verdict.acq_ok = err <= acq_tol;
        verdict.rel_ok = err <= rel_tol;
    end

endmodule

// File: rtl/fld_lockfsm.sv
module fld_lockfsm
    import fld_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  fld_verdict_t verdict,
    input  logic         rd_stb,
    output logic         lock,
    output logic         lol_pulse,
    output logic         rd_lock
);
    fld_state_e st;

    assign lock = (st == ST_LOCKED);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_HUNT;
            lol_pulse <= 1'b0;
            rd_lock   <= 1'b0;
        end else begin
            lol_pulse <= 1'b0;
            if (rd_stb) rd_lock <= lock;
            if (restart) begin
                st <= ST_HUNT;
            end else if (verdict.vld) begin
                case (st)
                    ST_HUNT:   if (verdict.acq_ok) st <= ST_QUAL;
                    ST_QUAL:   st <= verdict.acq_ok ? ST_LOCKED : ST_HUNT;
                    ST_LOCKED: if (!verdict.rel_ok) begin
                                   st        <= ST_HUNT;
                                   lol_pulse <= 1'b1;
                               end
                    default:   st <= ST_HUNT;
                endcase
            end
        end
    end

    // R3
    lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lock) |-> $past(verdict.vld && verdict.acq_ok));
    // R5
    lol_single_chk: assert property (@(posedge clk) disable iff (rst)
        lol_pulse |=> !lol_pulse);
    // R5
    lol_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        lol_pulse |-> (!lock && $past(lock)));
    // R4
    lock_drop_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $fell(lock)) |-> (lol_pulse || $past(restart)));
    // R8
    rd_prev_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rd_stb && !rst) |-> (rd_lock == $past(lock)));

endmodule

// File: rtl/freq_lock_detect.sv
module freq_lock_detect
    import fld_pkg::*;
#(
    parameter int unsigned WIN_LEN = 256,
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned INC_W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] exp_cnt,
    input  logic [1:0]       mode,
    input  logic             rd_stb,
    input  logic [INC_W-1:0] edge_inc,
    output logic             lock,
    output logic             lol_pulse,
    output logic             rst_ok,
    output logic             rd_lock
);
    localparam int unsigned ACC_W = CNT_W + 1;

    logic [CNT_W-1:0] exp_q;
    logic [1:0]       mode_q;
    logic             restart;
    logic             meas_vld;
    logic [ACC_W-1:0] meas_cnt;
    fld_verdict_t     verdict;

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_q  <= exp_cnt;
            mode_q <= mode;
        end else begin
            exp_q  <= exp_cnt;
            mode_q <= mode;
        end
    end

    assign restart = (exp_cnt != exp_q) || (mode != mode_q) || is_ext(mode);

    fld_window #(
        .WIN_LEN (WIN_LEN),
        .INC_W   (INC_W),
        .ACC_W   (ACC_W)
    ) u_win (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .edge_inc (edge_inc),
        .meas_vld (meas_vld),
        .meas_cnt (meas_cnt)
    );

    fld_judge #(
        .CNT_W (CNT_W),
        .ACC_W (ACC_W)
    ) u_judge (
        .meas_vld (meas_vld),
        .meas_cnt (meas_cnt),
        .exp_cnt  (exp_q),
        .verdict  (verdict)
    );

    fld_lockfsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .verdict   (verdict),
        .rd_stb    (rd_stb),
        .lock      (lock),
        .lol_pulse (lol_pulse),
        .rd_lock   (rd_lock)
    );

    assign rst_ok = lock && !is_ext(mode_q);

    // R7
    ext_clear_chk: assert property (@(posedge clk) disable iff (rst)
        is_ext(mode) |=> (!lock && !rst_ok));
    // R6
    restart_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> (!lock && !lol_pulse));

endmodule

// File: tb/tb_freq_lock_detect.sv
module tb_freq_lock_detect;
    import fld_pkg::*;

    localparam int unsigned W     = 16;
    localparam int unsigned CNT_W = 16;
    localparam int unsigned INC_W = 8;
    localparam int unsigned NOM   = 1600;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [CNT_W-1:0] exp_cnt = CNT_W'(NOM);
    logic [1:0]       mode = 2'b00;
    logic             rd_stb = 1'b0;
    logic [INC_W-1:0] edge_inc = '0;
    logic             lock, lol_pulse, rst_ok, rd_lock;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    freq_lock_detect #(.WIN_LEN(W), .CNT_W(CNT_W), .INC_W(INC_W)) dut (
        .clk(clk), .rst(rst), .exp_cnt(exp_cnt), .mode(mode), .rd_stb(rd_stb),
        .edge_inc(edge_inc), .lock(lock), .lol_pulse(lol_pulse),
        .rst_ok(rst_ok), .rd_lock(rd_lock)
    );

    typedef struct packed {
        logic [15:0] total;
        logic        lk;
        logic        lol;
        logic        rd;
    } vec_t;

    // window total, expected lock after it, expected loss pulse, read on its result edge
    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{16'd1612, 1'b0, 1'b0, 1'b0},  // +12 inside tight band (R2), first good
        '{16'd1588, 1'b1, 1'b0, 1'b1},  // -12 second good, lock sets (R3), read coincides
        '{16'd1625, 1'b1, 1'b0, 1'b1},  // +25 inside loose band (R4)
        '{16'd1575, 1'b1, 1'b0, 1'b0},  // -25 inside loose band (R4)
        '{16'd1626, 1'b0, 1'b1, 1'b1},  // +26 outside, lock lost (R5), read coincides
        '{16'd1600, 1'b0, 1'b0, 1'b0},
        '{16'd1613, 1'b0, 1'b0, 1'b0},  // +13 outside tight band: qualification lost (R2)
        '{16'd1600, 1'b0, 1'b0, 1'b0},
        '{16'd1600, 1'b1, 1'b0, 1'b0},
        '{16'd1574, 1'b0, 1'b1, 1'b0},  // -26 outside loose band
        '{16'd1600, 1'b0, 1'b0, 1'b0},
        '{16'd1600, 1'b1, 1'b0, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
        end
    endtask

    // Drives one window; at its second cycle checks the outcome of the window before.
    task automatic run_win(input int total, input bit chk, input bit e_lock, input bit e_lol,
                           input bit do_rd, input bit e_rd);
        for (int i = 0; i < int'(W); i++) begin
            @(negedge clk);
            rst = 1'b0;
            if (i == 1 && chk) begin
                check("R3,R4 lock", {31'd0, lock}, {31'd0, e_lock});
                check("R5 lol_pulse", {31'd0, lol_pulse}, {31'd0, e_lol});
                check("R9 rst_ok", {31'd0, rst_ok}, {31'd0, e_lock && (mode != 2'b10)});
                if (do_rd) check("R8 rd_lock", {31'd0, rd_lock}, {31'd0, e_rd});
            end
            if (i == 2 && chk) check("R5 lol_pulse width", {31'd0, lol_pulse}, 32'd0);
            rd_stb   = (i == 0) && do_rd;
            edge_inc = INC_W'(total / int'(W) + ((i == 0) ? total % int'(W) : 0));
        end
    endtask

    initial begin
        #(20 * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 lock", {31'd0, lock}, 32'd0);
        check("R10 lol_pulse", {31'd0, lol_pulse}, 32'd0);
        check("R10 rst_ok", {31'd0, rst_ok}, 32'd0);
        check("R10 rd_lock", {31'd0, rd_lock}, 32'd0);

        // R1: windows line up back to back from reset release
        for (int k = 0; k < NV; k++) begin
            run_win(int'(VEC[k].total), k > 0,
                    (k > 0) ? VEC[k-1].lk : 1'b0,
                    (k > 0) ? VEC[k-1].lol : 1'b0,
                    (k > 0) ? VEC[k-1].rd : 1'b0,
                    (k > 1) ? VEC[k-2].lk : 1'b0);
        end
        run_win(NOM, 1'b1, VEC[NV-1].lk, VEC[NV-1].lol, VEC[NV-1].rd, VEC[NV-2].lk);

        // R6: count change drops lock with no loss pulse, then restarts
        @(negedge clk);
        check("R4 lock held", {31'd0, lock}, 32'd1);
        exp_cnt  = CNT_W'(NOM + 1);
        edge_inc = '0;
        @(negedge clk);
        check("R6 lock cleared", {31'd0, lock}, 32'd0);
        check("R6 no lol_pulse", {31'd0, lol_pulse}, 32'd0);
        exp_cnt = CNT_W'(NOM);
        run_win(NOM, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        run_win(NOM, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        run_win(NOM, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);   // R6 R1 restart alignment

        // R7: external clock mode holds everything low
        @(negedge clk);
        mode = 2'b10;
        run_win(NOM, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        run_win(NOM, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        run_win(NOM, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check("R7 lock ext", {31'd0, lock}, 32'd0);
        check("R7 rst_ok ext", {31'd0, rst_ok}, 32'd0);
        check("R7 no lol_pulse", {31'd0, lol_pulse}, 32'd0);
        mode = 2'b01;
        run_win(NOM, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        run_win(NOM, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        run_win(NOM, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);   // R7 1:1 mode locks again

        // R10: reset in the middle of a lock
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R10 lock after reset", {31'd0, lock}, 32'd0);
        check("R10 rst_ok after reset", {31'd0, rst_ok}, 32'd0);
        run_win(NOM, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        run_win(NOM, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        run_win(NOM, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);   // R1 counters restarted by reset

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule